// File: doc/BRIEF.md
# External Bus Hold Arbiter with Bus Sizing

This block decides who owns a shared external address/data bus: the local CPU or an outside master. The outside master asks for the bus by pulling an active-low hold request low. The block frees its bus pins, then answers with an active-low hold acknowledge. When the request goes high again, the block takes the bus back. While the bus is held, CPU accesses that need only on-chip memory still complete. An access that needs the external bus, or an on-chip peripheral register behind it, waits until the hold ends.

CPU accesses can be a byte, a halfword or a word. A sizing sequencer splits each one into one-clock bus sub-cycles on an 8-bit or 16-bit external bus. For reads it puts the data back together. A hold is never granted between the sub-cycles of one access. It is also never granted between a locked read-modify-write read and the write that follows it.

Top module: `ext_bus_hold_arb`

## Requirements
- R1: After reset, hold_ack_n is 1, ext_oe is 1, both strobes are 1 and cpu_ack is 0.
- R2: hold_req_n passes through two synchronizer flops. If the bus is idle and hold_req_n is first sampled low at clock edge 1, ext_oe drops after edge 3. hold_ack_n drops after edge 4, one turnaround cycle later.
- R3: Whenever hold_ack_n is 0, ext_oe is 0 and both strobes read 1.
- R4: If hold_req_n is first sampled high at edge 1 during a hold, hold_ack_n returns to 1 and ext_oe to 1 together, after edge 3.
- R5: An access with cpu_local=1 raises cpu_ack for one cycle, in the cycle right after it is accepted. This holds even during a hold. It causes no bus strobe.
- R6: An access with cpu_local=0 starts no bus sub-cycle while the bus is held. It completes after the hold ends.
- R7: With bus_wide=1 (16-bit bus), the sub-cycle counts are fixed by access and address:
  - word at an even address: 2
  - word at an odd address: 3
  - halfword at an odd address: 2
  - halfword at an even address: 1
  - byte: 1
- R8: With bus_wide=0 (8-bit bus), a word takes 4 sub-cycles, a halfword 2 and a byte 1.
- R9: Each sub-cycle moves one or two bytes, and its rules are:
  - Sub-cycles start at the CPU address and step upward by the number of bytes moved.
  - The 16-bit bus moves two bytes only from an even address.
  - On the 16-bit bus, lane [7:0] / ext_be[0] carries the even byte and lane [15:8] / ext_be[1] the odd byte.
  - On the 8-bit bus, only lane [7:0] is used.
  - The byte at CPU address+i maps to cpu_wdata/cpu_rdata bits [8i+7:8i]. Read bytes beyond the access size are 0.
  - cpu_size encodes 00 byte, 01 halfword, 10 word.
- R10: A hold request is never granted while a sub-cycle sequence is in progress. It is granted on the first cycle after the sequence ends, ahead of any new external CPU access.
- R11: After an access with cpu_lock=1, no hold is granted until the next external access has completed.
- R12: cpu_ack is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_local | input | 1 | Access targets on-chip memory only |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_lock | input | 1 | Locked read of a read-modify-write pair |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data, byte i at bits [8i+7:8i] |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Reassembled read data, valid with cpu_ack |
| bus_wide | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| hold_req_n | input | 1 | Active-low hold request from external master |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| ext_oe | output | 1 | Pad output enable; 0 = pins high-impedance |
| ext_addr | output | ADDR_W | Sub-cycle byte address |
| ext_wdata | output | 16 | Write data lanes |
| ext_be | output | 2 | Lane enables |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_rdata | input | 16 | Read data lanes |

## Verification
A hold request can land in the same cycle as a multi-cycle sized access, or in the gap between a locked read and its write. The bench provokes this by dropping hold_req_n on the very cycle a CPU access is issued. It also drops it while a locked pair is waiting for its write. A guard window covers each protected stretch, and the bench judges every cycle in it: hold_ack_n must stay high. The bench then checks that the sub-cycle count, the read data or written bytes are intact, and that the grant comes only after the sequence.

// File: rtl/bha_pkg.sv
// Package: shared encodings for the bus hold arbiter.
// Assumes a 32-bit CPU data path and a 16-bit maximum external bus.
package bha_pkg;
    localparam int CPU_DW = 32;
    localparam int BUS_DW = 16;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        HB_OWN     = 2'd0,
        HB_RELEASE = 2'd1,
        HB_HELD    = 2'd2
    } hold_state_e;

    // Number of bytes an access of the given size code moves.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   size_bytes = 3'd1;
            2'b01:   size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bha_sizer.sv
// Module: bus-sizing sequencer.
// Accepts one CPU access at a time. A local access completes in one cycle.
// An external access is split into one-clock sub-cycles of one or two bytes.
// Assumes cpu_req is held until cpu_ack and inputs are stable meanwhile.
module bha_sizer
    import bha_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_local,
    input  logic              cpu_we,
    input  logic              cpu_lock,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [CPU_DW-1:0] cpu_rdata,
    input  logic              bus_wide,
    input  logic              ext_allow,
    output logic              seq_busy,
    output logic              lock_pend,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    output logic [1:0]        bus_be,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    input  logic [BUS_DW-1:0] bus_rdata
);
    localparam int NBYTES = CPU_DW / 8;

    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [2:0]        rem;
    logic [1:0]        off;
    logic              we_q;
    logic              lock_q;
    logic [CPU_DW-1:0] wbuf;
    logic [CPU_DW-1:0] rbuf;

    logic              two;
    logic [2:0]        step;
    logic [15:0]       sh;
    logic [7:0]        b_lo;
    logic              start_ext;
    logic              start_loc;

    // Size of the current sub-cycle and the write bytes it carries.
    always_comb begin
        two  = bus_wide && !cur_addr[0] && (rem >= 3'd2);
        step = two ? 3'd2 : 3'd1;
        sh   = 16'(wbuf >> {off, 3'b000});
        b_lo = (bus_wide && cur_addr[0]) ? bus_rdata[15:8] : bus_rdata[7:0];
    end

    // Accept decisions for local and external accesses.
    always_comb begin
        start_loc = (state == SQ_IDLE) && cpu_req && cpu_local;
        start_ext = (state == SQ_IDLE) && cpu_req && !cpu_local && ext_allow;
    end

    // Lane steering and byte enables of the active sub-cycle.
    always_comb begin
        bus_be    = 2'b00;
        bus_wdata = '0;
        if (state == SQ_XFER) begin
            if (!bus_wide) begin
                bus_be    = 2'b01;
                bus_wdata = {8'h00, sh[7:0]};
            end else if (cur_addr[0]) begin
                bus_be    = 2'b10;
                bus_wdata = {sh[7:0], 8'h00};
            end else if (two) begin
                bus_be    = 2'b11;
                bus_wdata = sh;
            end else begin
                bus_be    = 2'b01;
                bus_wdata = {8'h00, sh[7:0]};
            end
        end
    end

    // Sequencer state, address stepping and read reassembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            off      <= '0;
            we_q     <= 1'b0;
            lock_q   <= 1'b0;
            wbuf     <= '0;
            rbuf     <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_loc) begin
                        state <= SQ_DONE;
                    end else if (start_ext) begin
                        state    <= SQ_XFER;
                        cur_addr <= cpu_addr;
                        rem      <= size_bytes(cpu_size);
                        off      <= 2'd0;
                        we_q     <= cpu_we;
                        lock_q   <= cpu_lock;
                        wbuf     <= cpu_wdata;
                        rbuf     <= '0;
                    end
                end
                SQ_XFER: begin
                    cur_addr <= cur_addr + ADDR_W'(step);
                    off      <= off + step[1:0];
                    rem      <= rem - step;
                    if (!we_q) begin
                        for (int k = 0; k < NBYTES; k++) begin
                            if (2'(k) == off)
                                rbuf[k*8 +: 8] <= b_lo;
                            if (two && (2'(k) == off + 2'd1))
                                rbuf[k*8 +: 8] <= bus_rdata[15:8];
                        end
                    end
                    if (rem == step)
                        state <= SQ_DONE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cpu_ack   = (state == SQ_DONE);
    assign cpu_rdata = rbuf;
    assign seq_busy  = (state == SQ_XFER);
    assign lock_pend = lock_q;
    assign bus_addr  = cur_addr;
    assign bus_rd_n  = !((state == SQ_XFER) && !we_q);
    assign bus_wr_n  = !((state == SQ_XFER) && we_q);

    // R6
    xfer_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_XFER) && ($past(state) == SQ_IDLE)) |-> $past(ext_allow));

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

// File: rtl/bha_hold_ctl.sv
// Module: hold request synchronizer and ownership state machine.
// Grants the bus only when the sequencer is idle and no locked pair is open.
// Releases the pins for one turnaround cycle before acknowledging.
// Assumes hold_req_n is asynchronous to clk.
module bha_hold_ctl
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic seq_busy,
    input  logic lock_pend,
    output logic ext_allow,
    output logic drive_en,
    output logic hold_ack_n
);
    logic [SYNC_STAGES-1:0] sq;
    logic                   sreq;
    logic                   grant;
    hold_state_e            st;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            // Shift the raw request through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= '1;
                else        sq <= {sq[SYNC_STAGES-2:0], hold_req_n};
            end
        end else begin : g_single
            // Single-flop capture of the raw request.
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= '1;
                else        sq <= hold_req_n;
            end
        end
    endgenerate

    assign sreq = !sq[SYNC_STAGES-1];

    // Grant condition and permission for new external CPU accesses.
    always_comb begin
        grant     = (st == HB_OWN) && sreq && !seq_busy && !lock_pend;
        ext_allow = (st == HB_OWN) && !(sreq && !lock_pend);
    end

    // Ownership state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= HB_OWN;
        end else begin
            case (st)
                HB_OWN:     if (grant) st <= HB_RELEASE;
                HB_RELEASE: st <= HB_HELD;
                HB_HELD:    if (!sreq) st <= HB_OWN;
                default:    st <= HB_OWN;
            endcase
        end
    end

    assign drive_en   = (st == HB_OWN);
    assign hold_ack_n = (st != HB_HELD);

    // R10
    grant_outside_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HB_RELEASE) |-> $past(!seq_busy && !lock_pend));

    // R2
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(!drive_en));
endmodule

// File: rtl/ext_bus_hold_arb.sv
// Module: top of the external bus hold arbiter.
// Joins the sizing sequencer and the hold controller, and gates the pad
// outputs with the ownership enable. Released pins show quiet values and
// ext_oe=0, which the pad ring turns into high impedance.
module ext_bus_hold_arb
    import bha_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_local,
    input  logic              cpu_we,
    input  logic              cpu_lock,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ack,
    output logic [31:0]       cpu_rdata,
    input  logic              bus_wide,
    input  logic              hold_req_n,
    output logic              hold_ack_n,
    output logic              ext_oe,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [15:0]       ext_wdata,
    output logic [1:0]        ext_be,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    input  logic [15:0]       ext_rdata
);
    logic              ext_allow;
    logic              seq_busy;
    logic              lock_pend;
    logic              drive_en;
    logic [ADDR_W-1:0] bus_addr;
    logic [15:0]       bus_wdata;
    logic [1:0]        bus_be;
    logic              bus_rd_n;
    logic              bus_wr_n;

    bha_sizer #(.ADDR_W(ADDR_W)) sizer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_local (cpu_local),
        .cpu_we    (cpu_we),
        .cpu_lock  (cpu_lock),
        .cpu_size  (cpu_size),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .bus_wide  (bus_wide),
        .ext_allow (ext_allow),
        .seq_busy  (seq_busy),
        .lock_pend (lock_pend),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_rdata (ext_rdata)
    );

    bha_hold_ctl #(.SYNC_STAGES(SYNC_STAGES)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req_n (hold_req_n),
        .seq_busy   (seq_busy),
        .lock_pend  (lock_pend),
        .ext_allow  (ext_allow),
        .drive_en   (drive_en),
        .hold_ack_n (hold_ack_n)
    );

    // Pad gating: released pins carry idle values with the enable low.
    always_comb begin
        ext_oe    = drive_en;
        ext_addr  = drive_en ? bus_addr  : '0;
        ext_wdata = drive_en ? bus_wdata : '0;
        ext_be    = drive_en ? bus_be    : 2'b00;
        ext_rd_n  = drive_en ? bus_rd_n  : 1'b1;
        ext_wr_n  = drive_en ? bus_wr_n  : 1'b1;
    end

    // R3
    released_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (!ext_oe && ext_rd_n && ext_wr_n));

    // R6
    bus_owned_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> ext_oe);
endmodule

// File: tb/ext_bus_hold_arb_tb.sv
module ext_bus_hold_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_local = 1'b0, cpu_we = 1'b0, cpu_lock = 1'b0;
    logic [1:0]  cpu_size = 2'b00;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        bus_wide = 1'b1;
    logic        hold_req_n = 1'b1;
    logic        hold_ack_n, ext_oe, ext_rd_n, ext_wr_n;
    logic [15:0] ext_addr, ext_wdata, ext_rdata;
    logic [1:0]  ext_be;

    int checks = 0;
    int fails = 0;
    int strobe_cnt = 0;
    int first_addr = -1;
    bit guard = 1'b0;
    bit done = 1'b0;
    logic [7:0] wmem [256];

    always #5 clk = ~clk;

    ext_bus_hold_arb dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_local(cpu_local),
        .cpu_we(cpu_we), .cpu_lock(cpu_lock), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .bus_wide(bus_wide), .hold_req_n(hold_req_n),
        .hold_ack_n(hold_ack_n), .ext_oe(ext_oe), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_be(ext_be), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_rdata(ext_rdata)
    );

    function automatic logic [7:0] memf(input logic [7:0] a);
        return (a * 8'd29) ^ 8'h6B;
    endfunction

    assign ext_rdata = bus_wide ? {memf(ext_addr[7:0] | 8'h01), memf(ext_addr[7:0] & 8'hFE)}
                                : {8'h00, memf(ext_addr[7:0])};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bus monitor: strobe counting, write capture, hold and guard checks.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ext_rd_n == 1'b0 || ext_wr_n == 1'b0) begin
                strobe_cnt++;
                if (first_addr < 0) first_addr = int'(ext_addr);
            end
            if (ext_wr_n == 1'b0) begin
                if (bus_wide) begin
                    if (ext_be[0]) wmem[{ext_addr[7:1], 1'b0}] = ext_wdata[7:0];
                    if (ext_be[1]) wmem[{ext_addr[7:1], 1'b1}] = ext_wdata[15:8];
                end else if (ext_be[0]) begin
                    wmem[ext_addr[7:0]] = ext_wdata[7:0];
                end
            end
            if (hold_ack_n == 1'b0)
                check(!ext_oe && ext_rd_n && ext_wr_n, "R3", "pins released in hold",
                      {29'd0, ext_oe, ext_rd_n, ext_wr_n}, 32'd3);
            if (guard)
                check(hold_ack_n == 1'b1, "R10/R11", "no grant in protected window",
                      {31'd0, hold_ack_n}, 32'd1);
        end
    end

    // Issue one access right after a falling edge; return when it completes.
    task automatic do_access(input logic wide, input logic loc, input logic we,
                             input logic lock, input logic [1:0] sz,
                             input logic [15:0] addr, input logic [31:0] wd,
                             output logic [31:0] rd, output int cyc);
        bus_wide = wide; cpu_local = loc; cpu_we = we; cpu_lock = lock;
        cpu_size = sz; cpu_addr = addr; cpu_wdata = wd; cpu_req = 1'b1;
        strobe_cnt = 0; first_addr = -1; cyc = 0; rd = '0;
        while (cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cpu_ack) begin
                rd = cpu_rdata;
                break;
            end
        end
        cpu_req = 1'b0;
    endtask

    // {wide, size, addr, we, expected sub-cycles}
    localparam logic [14:0] VEC [14] = '{
        {1'b1, 2'd2, 8'h10, 1'b0, 3'd2}, {1'b1, 2'd2, 8'h21, 1'b0, 3'd3},
        {1'b1, 2'd1, 8'h33, 1'b0, 3'd2}, {1'b1, 2'd1, 8'h44, 1'b0, 3'd1},
        {1'b1, 2'd0, 8'h55, 1'b0, 3'd1}, {1'b0, 2'd2, 8'h60, 1'b0, 3'd4},
        {1'b0, 2'd1, 8'h71, 1'b0, 3'd2}, {1'b0, 2'd0, 8'h83, 1'b0, 3'd1},
        {1'b1, 2'd2, 8'h91, 1'b1, 3'd3}, {1'b1, 2'd2, 8'hA0, 1'b1, 3'd2},
        {1'b0, 2'd2, 8'hB2, 1'b1, 3'd4}, {1'b1, 2'd1, 8'hC5, 1'b1, 3'd2},
        {1'b1, 2'd0, 8'hD6, 1'b1, 3'd1}, {1'b0, 2'd1, 8'hE7, 1'b1, 3'd2}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, exp;
        int cyc, n, z_at, ack_at;
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hold_ack_n == 1'b1, "R1", "hold_ack_n", {31'd0, hold_ack_n}, 1);
        check(ext_oe == 1'b1, "R1", "ext_oe", {31'd0, ext_oe}, 1);
        check(ext_rd_n && ext_wr_n, "R1", "strobes", {30'd0, ext_rd_n, ext_wr_n}, 3);
        check(cpu_ack == 1'b0, "R1", "cpu_ack", {31'd0, cpu_ack}, 0);

        // Vector table: sub-cycle counts (R7, R8), order and data (R9)
        for (int v = 0; v < 14; v++) begin
            logic [31:0] wd;
            wd = 32'h1122_3344 + 32'(v) * 32'h0101_0101;
            for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
            do_access(VEC[v][14], 1'b0, VEC[v][3], 1'b0, VEC[v][13:12],
                      {8'h00, VEC[v][11:4]}, wd, rd, cyc);
            n = (VEC[v][13:12] == 2'd0) ? 1 : (VEC[v][13:12] == 2'd1) ? 2 : 4;
            check(strobe_cnt == int'(VEC[v][2:0]), VEC[v][14] ? "R7" : "R8",
                  "sub-cycle count", 32'(strobe_cnt), 32'(VEC[v][2:0]));
            check(first_addr == int'(VEC[v][11:4]), "R9", "first sub-cycle address",
                  32'(first_addr), 32'(VEC[v][11:4]));
            if (!VEC[v][3]) begin
                exp = '0;
                for (int i = 0; i < n; i++) exp[i*8 +: 8] = memf(VEC[v][11:4] + 8'(i));
                check(rd == exp, "R9", "reassembled read", rd, exp);
            end else begin
                exp = '0; rd = '0;
                for (int i = 0; i < n; i++) begin
                    exp[i*8 +: 8] = wd[i*8 +: 8];
                    rd[i*8 +: 8] = wmem[VEC[v][11:4] + 8'(i)];
                end
                check(rd == exp, "R9", "written bytes", rd, exp);
            end
            @(negedge clk);
        end

        // R2: synchronizer and turnaround latency
        hold_req_n = 1'b0; z_at = -1; ack_at = -1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (z_at < 0 && !ext_oe) z_at = i;
            if (ack_at < 0 && !hold_ack_n) ack_at = i;
        end
        check(z_at == 3, "R2", "pins released edge", 32'(z_at), 3);
        check(ack_at == 4, "R2", "acknowledge edge", 32'(ack_at), 4);

        // R5: local access completes during hold without strobes
        do_access(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 16'h0004, '0, rd, cyc);
        check(cyc == 1, "R5", "local access latency", 32'(cyc), 1);
        check(strobe_cnt == 0, "R5", "no strobe for local", 32'(strobe_cnt), 0);
        @(negedge clk);

        // R6: external access stalls during hold
        bus_wide = 1'b1; cpu_local = 1'b0; cpu_we = 1'b0; cpu_lock = 1'b0;
        cpu_size = 2'd1; cpu_addr = 16'h0046; cpu_req = 1'b1; strobe_cnt = 0;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cpu_ack) n++;
        end
        check(n == 0 && strobe_cnt == 0, "R6", "stall while held",
              32'(n + strobe_cnt), 0);

        // R4: release latency
        hold_req_n = 1'b1; ack_at = -1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (ack_at < 0 && hold_ack_n) begin
                ack_at = i;
                check(ext_oe == 1'b1, "R4", "pins driven with ack high", {31'd0, ext_oe}, 1);
            end
        end
        check(ack_at == 3, "R4", "release edge", 32'(ack_at), 3);
        cyc = 0;
        while (!cpu_ack && cyc < 20) begin @(negedge clk); cyc++; end
        rd = cpu_rdata;
        cpu_req = 1'b0;
        exp = {16'h0, memf(8'h47), memf(8'h46)};
        check(rd == exp, "R6", "stalled access completes", rd, exp);
        repeat (3) @(negedge clk);

        // R10: hold request lands with a 4-cycle narrow word read
        guard = 1'b1; hold_req_n = 1'b0;
        do_access(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 16'h0040, '0, rd, cyc);
        guard = 1'b0;
        check(strobe_cnt == 4, "R10", "sequence unbroken", 32'(strobe_cnt), 4);
        exp = {memf(8'h43), memf(8'h42), memf(8'h41), memf(8'h40)};
        check(rd == exp, "R10", "read intact", rd, exp);
        cpu_addr = 16'h0048; cpu_size = 2'd0; cpu_req = 1'b1; strobe_cnt = 0;
        cyc = 0;
        while (hold_ack_n && cyc < 10) begin @(negedge clk); cyc++; end
        check(hold_ack_n == 1'b0, "R10", "pending hold granted", {31'd0, hold_ack_n}, 0);
        check(strobe_cnt == 0, "R10", "no new access before grant", 32'(strobe_cnt), 0);
        hold_req_n = 1'b1;
        cyc = 0;
        while (!cpu_ack && cyc < 20) begin @(negedge clk); cyc++; end
        cpu_req = 1'b0;
        check(cpu_ack == 1'b1, "R10", "second access completes after hold", {31'd0, cpu_ack}, 1);
        repeat (3) @(negedge clk);

        // R11: locked pair is not split by a hold
        for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
        guard = 1'b1; hold_req_n = 1'b0;
        do_access(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0050, '0, rd, cyc);
        repeat (6) @(negedge clk);
        check(hold_ack_n == 1'b1, "R11", "no grant after locked read", {31'd0, hold_ack_n}, 1);
        do_access(1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 16'h0052, 32'h0000_BEEF, rd, cyc);
        guard = 1'b0;
        check({wmem[8'h53], wmem[8'h52]} == 16'hBEEF, "R11", "write of pair done",
              {16'h0, wmem[8'h53], wmem[8'h52]}, 32'h0000_BEEF);
        cyc = 0;
        while (hold_ack_n && cyc < 10) begin @(negedge clk); cyc++; end
        check(hold_ack_n == 1'b0, "R11", "grant after pair", {31'd0, hold_ack_n}, 0);
        hold_req_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: back-to-back local accesses never give a two-cycle ack
        cpu_local = 1'b1; cpu_req = 1'b1; n = 0; cyc = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cpu_ack && cyc == 1) n++;
            cyc = cpu_ack ? 1 : 0;
        end
        cpu_req = 1'b0;
        check(n == 0, "R12", "ack pulse width", 32'(n), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule